// File: doc/BRIEF.md
# Microcycle Phase Timing Sequencer

This block steps a processor through its per-microinstruction time states, one state per fast-clock period. A microcycle is split into a phase half (states PT1 to PT4) and a phase-bar half (states PBT1 to PBT4). A master clock level runs high for the whole phase half and low for the whole phase-bar half. The simplest microcycle is four fast periods long, which means each fast period is a quarter of a basic microcycle.

The sequencer lengthens a cycle to suit its operation.
- For a bus data transfer, PT2 repeats until the bus is granted, and PT3 repeats until the slave acknowledges.
- A read adds a PT4 deskew step. Read data is captured at the end of PT4.
- An address cycle strobes the address latch at the end of PT3.
- When relocation is enabled, the address cycle also runs PBT3 and PBT4 so that the translated address can be strobed.
- An abort or reset request sends any state other than PBT3 or PBT4 into PBT3 and then PBT4, after which the next microinstruction starts cleanly.

The cycle kind, the transfer code and the relocation enable are sampled on the edge that enters PT1. That is the same edge on which the microinstruction register loads.

Top module: `ucycle_phase_seq`

## Requirements
- R1: While rst_ni is low, the state is PBT4 (state_o bit 7), mclk_o is low and pa_strobe_o, data_latch_o and ctl_bits_o are 0. The first clock edge after release enters PT1.
- R2: Exactly one bit of state_o is set at all times. The bit order is PT1..PT4 = bits 0..3 and PBT1..PBT4 = bits 4..7. mclk_o is high exactly when a PT state is active.
- R3: A short cycle (cyc_kind_i 0, or the unused code 3) runs PT1, PT2, PBT1, PBT2 and then returns to PT1.
- R4: In a data cycle (cyc_kind_i 2), PT2 repeats for every clock in which bus_grant_i is low. It moves to PT3 on the first edge that sees bus_grant_i high.
- R5: In a data cycle, PT3 repeats until ssyn_i is seen high. A write (latched transfer code nonzero) then goes straight to PBT1.
- R6: A read (latched transfer code 0) goes PT3, PT4, PBT1. data_latch_o is high only during PT4.
- R7: An address cycle (cyc_kind_i 1) runs PT1, PT2, PT3, PBT1, PBT2. pa_strobe_o is high during PT3, and from PBT1 onward ctl_bits_o holds the transfer code latched for that cycle.
- R8: An address cycle with reloc_en_i high at PT1 entry runs PBT2, PBT3, PBT4 and then PT1, and pa_strobe_o is high again during PBT3.
- R9: abort_i seen in any state other than PBT3 or PBT4 forces PBT3 next, then PBT4, then PT1. In that forced PBT3, pa_strobe_o and data_latch_o stay low.
- R10: mir_load_o is high in exactly the cycle whose next state is PT1. The cycle kind, transfer code and relocation enable are captured on that edge.
- R11: reloc_en_i has no effect on short or data cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, one period per time state |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_kind_i | input | 2 | Cycle kind: 0 short, 1 address, 2 data, 3 treated as short |
| xfer_code_i | input | CODE_W | Transfer code, 0 = read, nonzero = write type |
| reloc_en_i | input | 1 | Address relocation enable |
| bus_grant_i | input | 1 | Bus is free for the data transfer |
| ssyn_i | input | 1 | Slave acknowledge |
| abort_i | input | 1 | Abort or reset request |
| state_o | output | 8 | One-hot time state |
| mclk_o | output | 1 | Master clock level, high in phase time |
| mir_load_o | output | 1 | Microinstruction register load, active on the edge into PT1 |
| pa_strobe_o | output | 1 | Address latch strobe |
| ctl_bits_o | output | CODE_W | Transfer code held in the address latch |
| data_latch_o | output | 1 | Read data capture strobe |

## Verification
The bench tests two cases where an abort lands in the same cycle as another event.

In the first case, abort_i and ssyn_i are raised together during the PT3 stall of a read. The bench expects PBT3 rather than PT4 on the next edge, and data_latch_o must stay low.

In the second case, an abort arrives in PBT2 of a relocating address cycle. Relocation would also have led to PBT3, so the bench tells the two apart by checking that pa_strobe_o stays low in that PBT3 and that ctl_bits_o keeps the code strobed in PT3.

// File: rtl/ucyc_pkg.sv
package ucyc_pkg;
  localparam int unsigned NSTATE = 8;
  localparam int S_PT1  = 0;
  localparam int S_PT2  = 1;
  localparam int S_PT3  = 2;
  localparam int S_PT4  = 3;
  localparam int S_PBT1 = 4;
  localparam int S_PBT2 = 5;
  localparam int S_PBT3 = 6;
  localparam int S_PBT4 = 7;

  typedef logic [NSTATE-1:0] tstate_t;

  typedef enum logic [1:0] {
    CK_SHORT = 2'd0,
    CK_ADDR  = 2'd1,
    CK_DATA  = 2'd2,
    CK_RSVD  = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/ucyc_next.sv
module ucyc_next
  import ucyc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  tstate_t   state_i,
  input  cyc_kind_e kind_i,
  input  logic      dir_in_i,
  input  logic      reloc_i,
  input  logic      grant_i,
  input  logic      ssyn_i,
  input  logic      abort_i,
  output tstate_t   nxt_o,
  output logic      forced_o,
  output logic      chg_clk_o
);

  localparam int PH_HI = NSTATE / 2;

  always_comb begin
    nxt_o    = '0;
    forced_o = 1'b0;
    if (abort_i && !state_i[S_PBT3] && !state_i[S_PBT4]) begin
      nxt_o[S_PBT3] = 1'b1;
      forced_o      = 1'b1;
    end else if (state_i[S_PT1]) begin
      nxt_o[S_PT2] = 1'b1;
    end else if (state_i[S_PT2]) begin
      unique case (kind_i)
        CK_ADDR: nxt_o[S_PT3] = 1'b1;
        CK_DATA: begin
          if (grant_i) nxt_o[S_PT3] = 1'b1;
          else         nxt_o[S_PT2] = 1'b1;
        end
        default: nxt_o[S_PBT1] = 1'b1;
      endcase
    end else if (state_i[S_PT3]) begin
      if (kind_i == CK_DATA) begin
        if (!ssyn_i)       nxt_o[S_PT3]  = 1'b1;
        else if (dir_in_i) nxt_o[S_PT4]  = 1'b1;
        else               nxt_o[S_PBT1] = 1'b1;
      end else begin
        nxt_o[S_PBT1] = 1'b1;
      end
    end else if (state_i[S_PT4]) begin
      nxt_o[S_PBT1] = 1'b1;
    end else if (state_i[S_PBT1]) begin
      nxt_o[S_PBT2] = 1'b1;
    end else if (state_i[S_PBT2]) begin
      if (reloc_i) nxt_o[S_PBT3] = 1'b1;
      else         nxt_o[S_PT1]  = 1'b1;
    end else if (state_i[S_PBT3]) begin
      nxt_o[S_PBT4] = 1'b1;
    end else begin
      nxt_o[S_PT1] = 1'b1;
    end
  end

  // phase flips whenever the half (PT vs PBT) changes
  assign chg_clk_o = (|nxt_o[PH_HI-1:0]) != (|state_i[PH_HI-1:0]);

  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && !state_i[S_PBT3] && !state_i[S_PBT4] |=> state_i[S_PBT3]);

  p_pt2_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i[S_PT2] && kind_i == CK_DATA && !grant_i && !abort_i |=> state_i[S_PT2]);

  p_pt3_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i[S_PT3] && kind_i == CK_DATA && !ssyn_i && !abort_i |=> state_i[S_PT3]);

endmodule

// File: rtl/ucyc_ctx.sv
module ucyc_ctx
  import ucyc_pkg::*;
#(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        kind_raw_i,
  input  logic              reloc_en_i,
  input  logic [CODE_W-1:0] xfer_i,
  input  logic              forced_i,
  output cyc_kind_e         kind_o,
  output logic              reloc_o,
  output logic              dir_in_o,
  output logic [CODE_W-1:0] xfer_o,
  output logic              aborting_o
);

  cyc_kind_e         kind_q;
  logic              reloc_q;
  logic [CODE_W-1:0] xfer_q;
  logic              abt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= CK_SHORT;
      reloc_q <= 1'b0;
      xfer_q  <= '0;
    end else if (load_i) begin
      kind_q  <= cyc_kind_e'(kind_raw_i);
      reloc_q <= reloc_en_i && (cyc_kind_e'(kind_raw_i) == CK_ADDR);
      xfer_q  <= xfer_i;
    end
  end

  // marks a PBT3/PBT4 pass entered by abort, not by relocation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       abt_q <= 1'b0;
    else if (forced_i) abt_q <= 1'b1;
    else if (load_i)   abt_q <= 1'b0;
  end

  assign kind_o     = kind_q;
  assign reloc_o    = reloc_q;
  assign xfer_o     = xfer_q;
  assign dir_in_o   = (xfer_q == '0);
  assign aborting_o = abt_q;

  p_reloc_addr_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reloc_q |-> kind_q == CK_ADDR);

endmodule

// File: rtl/ucyc_strobe.sv
module ucyc_strobe
  import ucyc_pkg::*;
#(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pt3_i,
  input  logic              pt4_i,
  input  logic              pbt3_i,
  input  cyc_kind_e         kind_i,
  input  logic              reloc_i,
  input  logic              aborting_i,
  input  logic              abort_i,
  input  logic [CODE_W-1:0] xfer_i,
  output logic              pa_strobe_o,
  output logic              data_latch_o,
  output logic [CODE_W-1:0] ctl_bits_o
);

  logic              va_stb;
  logic              pa_stb;
  logic [CODE_W-1:0] ctl_q;

  assign va_stb       = pt3_i && (kind_i == CK_ADDR) && !abort_i;
  assign pa_stb       = pbt3_i && reloc_i && !aborting_i && !abort_i;
  assign pa_strobe_o  = va_stb || pa_stb;
  assign data_latch_o = pt4_i && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ctl_q <= '0;
    else if (pa_strobe_o) ctl_q <= xfer_i;
  end

  assign ctl_bits_o = ctl_q;

  p_ctl_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_strobe_o |=> ctl_bits_o == $past(xfer_i));

  p_no_stb_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aborting_i |-> !pa_strobe_o && !data_latch_o);

endmodule

// File: rtl/ucyc_mclk.sv
module ucyc_mclk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_clk_i,
  output logic mclk_o
);

  logic mclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mclk_q <= 1'b0;
    else         mclk_q <= mclk_q ^ chg_clk_i;
  end

  assign mclk_o = mclk_q;

endmodule

// File: rtl/ucycle_phase_seq.sv
module ucycle_phase_seq
  import ucyc_pkg::*;
#(
  parameter int unsigned CODE_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            cyc_kind_i,
  input  logic [CODE_W-1:0]     xfer_code_i,
  input  logic                  reloc_en_i,
  input  logic                  bus_grant_i,
  input  logic                  ssyn_i,
  input  logic                  abort_i,
  output logic [NSTATE-1:0]     state_o,
  output logic                  mclk_o,
  output logic                  mir_load_o,
  output logic                  pa_strobe_o,
  output logic [CODE_W-1:0]     ctl_bits_o,
  output logic                  data_latch_o
);

  localparam tstate_t RST_STATE = tstate_t'(1) << S_PBT4;

  tstate_t           state_q;
  tstate_t           nxt;
  logic              forced;
  logic              chg_clk;
  cyc_kind_e         kind;
  logic              reloc;
  logic              dir_in;
  logic              aborting;
  logic [CODE_W-1:0] xfer;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RST_STATE;
    else         state_q <= nxt;
  end

  assign mir_load_o = nxt[S_PT1];

  ucyc_next u_next (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state_q),
    .kind_i    (kind),
    .dir_in_i  (dir_in),
    .reloc_i   (reloc),
    .grant_i   (bus_grant_i),
    .ssyn_i    (ssyn_i),
    .abort_i   (abort_i),
    .nxt_o     (nxt),
    .forced_o  (forced),
    .chg_clk_o (chg_clk)
  );

  ucyc_ctx #(.CODE_W(CODE_W)) u_ctx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (mir_load_o),
    .kind_raw_i (cyc_kind_i),
    .reloc_en_i (reloc_en_i),
    .xfer_i     (xfer_code_i),
    .forced_i   (forced),
    .kind_o     (kind),
    .reloc_o    (reloc),
    .dir_in_o   (dir_in),
    .xfer_o     (xfer),
    .aborting_o (aborting)
  );

  ucyc_strobe #(.CODE_W(CODE_W)) u_strobe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pt3_i        (state_q[S_PT3]),
    .pt4_i        (state_q[S_PT4]),
    .pbt3_i       (state_q[S_PBT3]),
    .kind_i       (kind),
    .reloc_i      (reloc),
    .aborting_i   (aborting),
    .abort_i      (abort_i),
    .xfer_i       (xfer),
    .pa_strobe_o  (pa_strobe_o),
    .data_latch_o (data_latch_o),
    .ctl_bits_o   (ctl_bits_o)
  );

  ucyc_mclk u_mclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chg_clk_i (chg_clk),
    .mclk_o    (mclk_o)
  );

  assign state_o = state_q;

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1);

  p_mclk_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk_o == (|state_q[S_PT4:S_PT1]));

  p_reset_exit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q[S_PBT4] && !abort_i |=> state_q[S_PT1]);

  p_mir_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mir_load_o |=> state_q[S_PT1]);

  p_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_latch_o |=> state_q[S_PBT1]);

endmodule

// File: tb/ucycle_phase_seq_test.sv
module ucycle_phase_seq_test;
  localparam int CW = 2;
  localparam int PT1 = 0, PT2 = 1, PT3 = 2, PT4 = 3;
  localparam int PBT1 = 4, PBT2 = 5, PBT3 = 6, PBT4 = 7;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    cyc_kind_i = '0;
  logic [CW-1:0] xfer_code_i = '0;
  logic          reloc_en_i = 1'b0;
  logic          bus_grant_i = 1'b0;
  logic          ssyn_i = 1'b0;
  logic          abort_i = 1'b0;
  logic [7:0]    state_o;
  logic          mclk_o, mir_load_o, pa_strobe_o, data_latch_o;
  logic [CW-1:0] ctl_bits_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  ucycle_phase_seq #(.CODE_W(CW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_kind_i(cyc_kind_i),
    .xfer_code_i(xfer_code_i), .reloc_en_i(reloc_en_i),
    .bus_grant_i(bus_grant_i), .ssyn_i(ssyn_i), .abort_i(abort_i),
    .state_o(state_o), .mclk_o(mclk_o), .mir_load_o(mir_load_o),
    .pa_strobe_o(pa_strobe_o), .ctl_bits_o(ctl_bits_o),
    .data_latch_o(data_latch_o)
  );

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // state plus phase level: R2 rides on every state check
  task automatic chk_st(input int idx, input string req);
    chk(state_o, 8'(1) << idx, req, "state");
    chk({7'd0, mclk_o}, {7'd0, (idx < 4)}, "R2", "mclk level");
  endtask

  task automatic t_short(input logic [1:0] k);
    cyc_kind_i = k; reloc_en_i = 1'b1;  // R11: ignored outside address cycles
    chk({7'd0, mir_load_o}, 8'd1, "R10", "load before PT1");
    step(); chk_st(PT1, "R3"); chk({7'd0, mir_load_o}, 8'd0, "R10", "load in PT1");
    step(); chk_st(PT2, "R3");
    step(); chk_st(PBT1, "R3");
    step(); chk_st(PBT2, "R11"); chk({7'd0, mir_load_o}, 8'd1, "R11", "load in PBT2");
    reloc_en_i = 1'b0;
  endtask

  task automatic t_data(input logic [CW-1:0] code, input int gwait, input int swait);
    cyc_kind_i = 2'd2; xfer_code_i = code; reloc_en_i = 1'b1;
    bus_grant_i = 1'b0; ssyn_i = 1'b0;
    step(); chk_st(PT1, "R4");
    step(); chk_st(PT2, "R4");
    for (int i = 0; i < gwait; i++) begin step(); chk_st(PT2, "R4"); end
    bus_grant_i = 1'b1;
    step(); chk_st(PT3, "R4"); bus_grant_i = 1'b0;
    for (int i = 0; i < swait; i++) begin
      step(); chk_st(PT3, "R5"); chk({7'd0, data_latch_o}, 8'd0, "R6", "latch in PT3");
    end
    ssyn_i = 1'b1;
    if (code == '0) begin
      step(); chk_st(PT4, "R6"); chk({7'd0, data_latch_o}, 8'd1, "R6", "latch in PT4");
      ssyn_i = 1'b0;
      step(); chk_st(PBT1, "R6"); chk({7'd0, data_latch_o}, 8'd0, "R6", "latch after PT4");
    end else begin
      step(); chk_st(PBT1, "R5"); ssyn_i = 1'b0;
      chk({7'd0, data_latch_o}, 8'd0, "R5", "no latch on write");
    end
    step(); chk_st(PBT2, "R11");
    reloc_en_i = 1'b0;
  endtask

  task automatic t_addr(input logic [CW-1:0] code, input logic rel);
    cyc_kind_i = 2'd1; xfer_code_i = code; reloc_en_i = rel;
    step(); chk_st(PT1, "R7");
    xfer_code_i = ~code;  // change after capture: must not reach ctl_bits
    step(); chk_st(PT2, "R7"); chk({7'd0, pa_strobe_o}, 8'd0, "R7", "strobe in PT2");
    step(); chk_st(PT3, "R7"); chk({7'd0, pa_strobe_o}, 8'd1, "R7", "strobe in PT3");
    step(); chk_st(PBT1, "R7"); chk({7'd0, pa_strobe_o}, 8'd0, "R7", "strobe in PBT1");
    chk(8'(ctl_bits_o), 8'(code), "R7", "ctl bits");
    step(); chk_st(PBT2, "R7");
    if (rel) begin
      chk({7'd0, mir_load_o}, 8'd0, "R8", "load in relocating PBT2");
      step(); chk_st(PBT3, "R8"); chk({7'd0, pa_strobe_o}, 8'd1, "R8", "strobe in PBT3");
      step(); chk_st(PBT4, "R8"); chk({7'd0, pa_strobe_o}, 8'd0, "R8", "strobe in PBT4");
      chk({7'd0, mir_load_o}, 8'd1, "R8", "load in PBT4");
    end
    reloc_en_i = 1'b0;
  endtask

  task automatic t_abort_pt2();
    cyc_kind_i = 2'd2; xfer_code_i = 2'd1; bus_grant_i = 1'b0;
    step(); chk_st(PT1, "R9");
    step(); chk_st(PT2, "R9");
    step(); chk_st(PT2, "R9");
    abort_i = 1'b1;
    step(); chk_st(PBT3, "R9"); chk({7'd0, pa_strobe_o}, 8'd0, "R9", "strobe in forced PBT3");
    abort_i = 1'b0;
    step(); chk_st(PBT4, "R9"); chk({7'd0, mir_load_o}, 8'd1, "R9", "load after abort");
  endtask

  task automatic t_abort_ssyn();
    cyc_kind_i = 2'd2; xfer_code_i = 2'd0; bus_grant_i = 1'b1;
    step(); chk_st(PT1, "R9");
    step(); chk_st(PT2, "R9");
    step(); chk_st(PT3, "R9"); bus_grant_i = 1'b0;
    ssyn_i = 1'b1; abort_i = 1'b1;
    step(); chk_st(PBT3, "R9"); chk({7'd0, data_latch_o}, 8'd0, "R9", "latch on abort");
    ssyn_i = 1'b0; abort_i = 1'b0;
    step(); chk_st(PBT4, "R9");
  endtask

  task automatic t_abort_reloc();
    cyc_kind_i = 2'd1; xfer_code_i = 2'd3; reloc_en_i = 1'b1;
    step(); chk_st(PT1, "R9"); reloc_en_i = 1'b0;
    step(); chk_st(PT2, "R9");
    step(); chk_st(PT3, "R9");
    step(); chk_st(PBT1, "R9");
    step(); chk_st(PBT2, "R9");
    abort_i = 1'b1;
    step(); chk_st(PBT3, "R9"); abort_i = 1'b0;
    chk({7'd0, pa_strobe_o}, 8'd0, "R9", "strobe in aborted PBT3");
    step(); chk_st(PBT4, "R9");
    chk(8'(ctl_bits_o), 8'd3, "R9", "ctl bits kept");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    chk_st(PBT4, "R1");
    chk({6'd0, pa_strobe_o, data_latch_o}, 8'd0, "R1", "strobes in reset");
    chk(8'(ctl_bits_o), 8'd0, "R1", "ctl bits in reset");
    step();
    rst_ni = 1'b1;
    t_short(2'd0);
    t_short(2'd3);
    t_data(2'd0, 0, 0);
    t_data(2'd0, 3, 2);
    t_data(2'd2, 2, 0);
    t_data(2'd1, 0, 4);
    t_addr(2'd2, 1'b0);
    t_addr(2'd1, 1'b1);
    t_abort_pt2();
    t_abort_ssyn();
    t_abort_reloc();
    t_short(2'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule